// File: doc/BRIEF.md
# Interrupt Translation Command Queue Engine

This block drains a ring of commands that software places in memory for an interrupt translation unit. Software advances a write index; whenever that index differs from the engine's read index, the engine fetches the 32-byte entry at the read index through a 64-bit memory port, identifies the command, carries it out and moves the read index on by one, wrapping at the configured ring size. Three commands are understood: map-collection (bind a collection number to a target processor, delivered as a request to a separate collection-table updater), map-device (write one device-table doubleword through the memory port) and sync (nothing to do but complete).

Errors fall into two classes. A command whose arguments are out of range, or whose type is unknown, is dropped and the ring keeps moving. A failed memory access or a refused table update freezes the ring: the read index stays on the failing entry and a stalled flag is raised until software clears it, after which the same entry is tried again.

Top module: `itq_cmd_engine`

## Requirements
- R1: After reset the read index is 0, the stalled flag is 0, and neither mem_req nor ct_req is asserted.
- R2: A write-index update with a value below QDEPTH starts processing, and entries are consumed until the read index equals the write index; an update with a value of QDEPTH or more is ignored.
- R3: Entry k occupies 32 bytes at Q_BASE + 32*k; the command type is bits [7:0] of its first doubleword, with 0x05 = sync, 0x08 = map-device, 0x09 = map-collection.
- R4: A map-collection command reads the doubleword at byte offset 16 of its entry and takes the collection number from bits [15:0], the processor number from bits [31:16] and the valid flag from bit 63; when the collection number is at most MAX_COLL and the processor number is below NUM_CPU it issues exactly one table-update request with those three values.
- R5: A map-collection command whose collection number exceeds MAX_COLL or whose processor number is NUM_CPU or more issues no request and the read index still advances.
- R6: A map-device command takes the device number from bits [63:32] of the first doubleword; when it is at most MAX_DEV the engine writes one doubleword at DT_BASE + 8*device, equal to the offset-16 doubleword if its bit 63 is set and zero otherwise; a larger device number causes no write and the read index advances.
- R7: A sync command causes exactly one memory read (the first doubleword), no write and no table-update request, and the read index advances.
- R8: A command with any other type code is skipped after its first doubleword is read, with no write or table-update request, and the read index advances.
- R9: The read index steps from QDEPTH-1 to 0, and otherwise by exactly one per completed command.
- R10: An error response on any memory read or write, or a refused table update, sets the stalled flag and leaves the read index on the failing entry; while stalled no memory or table request is made; a stall_clr pulse clears the flag and the same entry is processed again.
- R11: mem_req stays asserted with a stable address and direction until mem_ack, so a responder of any latency yields the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wptr_wr | input | 1 | Write-index update strobe |
| wptr_wdata | input | IDX_W | New write index (entry units) |
| stall_clr | input | 1 | Clears the stalled flag |
| rptr_o | output | IDX_W | Current read index (entry units) |
| stalled_o | output | 1 | Ring frozen by a failed access |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the doubleword |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Access complete (one cycle) |
| mem_err | input | 1 | Access failed, valid with mem_ack |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| ct_req | output | 1 | Collection-table update request, held until acknowledged |
| ct_id | output | 16 | Collection number |
| ct_proc | output | 16 | Target processor number |
| ct_valid | output | 1 | Map (1) or unmap (0) |
| ct_ack | input | 1 | Table update complete (one cycle) |
| ct_err | input | 1 | Table update refused, valid with ct_ack |

## Verification
The engine is driven with single commands of each type, batches that mix accepted and out-of-range arguments, and a run that crosses the end of the ring, so that skipping, dispatch and wraparound are each told apart by the read index and by the counts of reads, writes and table requests. Range limits are probed on both sides (the largest accepted collection, processor and device numbers and the first rejected ones), and a cleared valid flag shows that unmapping writes zero. Faults are injected on an entry read, a device-table write and a table update, then cleared, to separate the freezing error class from the skipping one and to show the retry lands on the same entry; a slow responder shows the results do not depend on latency.

// File: rtl/itq_pkg.sv
package itq_pkg;
    localparam logic [7:0] OP_SYNC = 8'h05;
    localparam logic [7:0] OP_MAPD = 8'h08;
    localparam logic [7:0] OP_MAPC = 8'h09;

    localparam int CID_W   = 16;
    localparam int PROC_W  = 16;
    localparam int PROC_LSB = 16;
    localparam int VLD_BIT = 63;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH0,
        ST_FETCH2,
        ST_DTWR,
        ST_CTREQ
    } itq_state_e;
endpackage

// File: rtl/itq_ring_ptr.sv
module itq_ring_ptr #(
    parameter int QDEPTH = 12,
    parameter int IDX_W  = 4
) (
    input  logic [IDX_W-1:0] cur,
    input  logic [IDX_W-1:0] wval,
    output logic [IDX_W-1:0] nxt,
    output logic             wval_ok
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(QDEPTH - 1);

    always_comb begin
        nxt     = (cur == LAST) ? '0 : cur + 1'b1;
        wval_ok = (wval <= LAST);
    end
endmodule

// File: rtl/itq_arg_check.sv
module itq_arg_check
    import itq_pkg::*;
#(
    parameter int NUM_CPU  = 4,
    parameter int MAX_COLL = 31,
    parameter int MAX_DEV  = 63
) (
    input  logic [7:0]        op,
    input  logic [31:0]       devid,
    input  logic [63:0]       dw2,
    output logic              need_dw2,
    output logic              ct_ok,
    output logic              dt_ok,
    output logic [CID_W-1:0]  coll_id,
    output logic [PROC_W-1:0] proc_num,
    output logic              map_vld,
    output logic [63:0]       dte
);
    localparam logic [CID_W-1:0]  COLL_LIM = CID_W'(MAX_COLL);
    localparam logic [PROC_W-1:0] PROC_LIM = PROC_W'(NUM_CPU);
    localparam logic [31:0]       DEV_LIM  = 32'(MAX_DEV);

    logic is_mapc, is_mapd;

    always_comb begin
        is_mapc  = (op == OP_MAPC);
        is_mapd  = (op == OP_MAPD);
        need_dw2 = is_mapc | is_mapd;
        coll_id  = dw2[CID_W-1:0];
        proc_num = dw2[PROC_LSB +: PROC_W];
        map_vld  = dw2[VLD_BIT];
        ct_ok    = is_mapc && (coll_id <= COLL_LIM) && (proc_num < PROC_LIM);
        dt_ok    = is_mapd && (devid <= DEV_LIM);
        dte      = dw2[VLD_BIT] ? dw2 : 64'd0;
    end
endmodule

// File: rtl/itq_cmd_engine.sv
module itq_cmd_engine
    import itq_pkg::*;
#(
    parameter int                QDEPTH   = 12,
    parameter int                NUM_CPU  = 4,
    parameter int                MAX_COLL = 31,
    parameter int                MAX_DEV  = 63,
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] Q_BASE   = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] DT_BASE  = 32'h0000_8000,
    localparam int               IDX_W    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wptr_wr,
    input  logic [IDX_W-1:0]  wptr_wdata,
    input  logic              stall_clr,
    output logic [IDX_W-1:0]  rptr_o,
    output logic              stalled_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [63:0]       mem_rdata,
    output logic              ct_req,
    output logic [15:0]       ct_id,
    output logic [15:0]       ct_proc,
    output logic              ct_valid,
    input  logic              ct_ack,
    input  logic              ct_err
);
    typedef struct packed {
        itq_state_e       st;
        logic [IDX_W-1:0] rptr;
        logic [IDX_W-1:0] wptr;
        logic             stalled;
        logic [7:0]       op;
        logic [31:0]      devid;
        logic [63:0]      dw2;
    } eng_t;

    eng_t q, d;

    logic [IDX_W-1:0] rptr_next;
    logic             wval_ok;
    logic [7:0]       op_in;
    logic [63:0]      dw2_in;
    logic             need_dw2, ct_ok, dt_ok, map_vld;
    logic [15:0]      coll_id, proc_num;
    logic [63:0]      dte;

    itq_ring_ptr #(.QDEPTH(QDEPTH), .IDX_W(IDX_W)) i_ring (
        .cur(q.rptr), .wval(wptr_wdata), .nxt(rptr_next), .wval_ok(wval_ok)
    );

    // decode the incoming word while it is on the bus, else the latched copy
    assign op_in  = (q.st == ST_FETCH0) ? mem_rdata[7:0] : q.op;
    assign dw2_in = (q.st == ST_FETCH2) ? mem_rdata : q.dw2;

    itq_arg_check #(.NUM_CPU(NUM_CPU), .MAX_COLL(MAX_COLL), .MAX_DEV(MAX_DEV)) i_chk (
        .op(op_in), .devid(q.devid), .dw2(dw2_in),
        .need_dw2(need_dw2), .ct_ok(ct_ok), .dt_ok(dt_ok),
        .coll_id(coll_id), .proc_num(proc_num), .map_vld(map_vld), .dte(dte)
    );

    always_comb begin
        d = q;
        if (wptr_wr && wval_ok) d.wptr = wptr_wdata;
        unique case (q.st)
            ST_IDLE: begin
                if (q.stalled) begin
                    if (stall_clr) d.stalled = 1'b0;
                end else if (q.rptr != q.wptr) begin
                    d.st = ST_FETCH0;
                end
            end
            ST_FETCH0: if (mem_ack) begin
                if (mem_err) begin
                    d.stalled = 1'b1;
                    d.st      = ST_IDLE;
                end else begin
                    d.op    = mem_rdata[7:0];
                    d.devid = mem_rdata[63:32];
                    if (need_dw2) begin
                        d.st = ST_FETCH2;
                    end else begin
                        d.rptr = rptr_next;
                        d.st   = ST_IDLE;
                    end
                end
            end
            ST_FETCH2: if (mem_ack) begin
                if (mem_err) begin
                    d.stalled = 1'b1;
                    d.st      = ST_IDLE;
                end else begin
                    d.dw2 = mem_rdata;
                    if (ct_ok)      d.st = ST_CTREQ;
                    else if (dt_ok) d.st = ST_DTWR;
                    else begin
                        d.rptr = rptr_next;
                        d.st   = ST_IDLE;
                    end
                end
            end
            ST_DTWR: if (mem_ack) begin
                d.st = ST_IDLE;
                if (mem_err) d.stalled = 1'b1;
                else         d.rptr    = rptr_next;
            end
            ST_CTREQ: if (ct_ack) begin
                d.st = ST_IDLE;
                if (ct_err) d.stalled = 1'b1;
                else        d.rptr    = rptr_next;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rptr_o    = q.rptr;
    assign stalled_o = q.stalled;
    assign mem_req   = (q.st == ST_FETCH0) || (q.st == ST_FETCH2) || (q.st == ST_DTWR);
    assign mem_we    = (q.st == ST_DTWR);
    assign mem_wdata = dte;
    assign ct_req    = (q.st == ST_CTREQ);
    assign ct_id     = coll_id;
    assign ct_proc   = proc_num;
    assign ct_valid  = map_vld;

    always_comb begin
        mem_addr = Q_BASE + (ADDR_W'(q.rptr) << 5);
        if (q.st == ST_FETCH2) mem_addr = Q_BASE + (ADDR_W'(q.rptr) << 5) + ADDR_W'(16);
        if (q.st == ST_DTWR)   mem_addr = DT_BASE + (ADDR_W'(q.devid) << 3);
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10
    no_req_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stalled_o |-> (!mem_req && !ct_req));

    // R10
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stalled_o |=> $stable(rptr_o));

    // R9
    rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr_o != $past(rptr_o)) |->
            (($past(rptr_o) == IDX_W'(QDEPTH - 1)) ? (rptr_o == '0)
                                                   : (rptr_o == $past(rptr_o) + 1'b1)));

    // R4
    ct_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ct_req |-> ((ct_id <= 16'(MAX_COLL)) && (ct_proc < 16'(NUM_CPU))));
endmodule

// File: tb/test_itq_cmd_engine.sv
module test_itq_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int QDEPTH = 12;
    localparam int IDX_W = 4;
    localparam logic [31:0] Q_BASE  = 32'h0000_1000;
    localparam logic [31:0] DT_BASE = 32'h0000_8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wptr_wr = 1'b0;
    logic [IDX_W-1:0] wptr_wdata = '0;
    logic stall_clr = 1'b0;
    logic [IDX_W-1:0] rptr_o;
    logic stalled_o, mem_req, mem_we, ct_req, ct_valid;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic mem_ack = 1'b0, mem_err = 1'b0, ct_ack = 1'b0, ct_err = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [15:0] ct_id, ct_proc;

    always #(CLK_PERIOD/2) clk = ~clk;

    itq_cmd_engine i_itq_cmd_engine (
        .clk(clk), .rst_n(rst_n), .wptr_wr(wptr_wr), .wptr_wdata(wptr_wdata),
        .stall_clr(stall_clr), .rptr_o(rptr_o), .stalled_o(stalled_o),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .ct_req(ct_req), .ct_id(ct_id), .ct_proc(ct_proc), .ct_valid(ct_valid),
        .ct_ack(ct_ack), .ct_err(ct_err)
    );

    logic [63:0] qmem [48];
    logic [63:0] dtmem [64];
    int rd_count = 0, wr_count = 0, ct_count = 0;
    logic [15:0] last_id, last_proc;
    logic last_vld;
    logic fail_en = 1'b0;
    logic [31:0] fail_addr = '0;
    logic ct_fail = 1'b0;
    int mem_lat = 0, wait_cnt = 0;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // memory and table-updater responders
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; mem_err <= 1'b0; ct_ack <= 1'b0; ct_err <= 1'b0; wait_cnt <= 0;
        end else begin
            mem_ack <= 1'b0; mem_err <= 1'b0; ct_ack <= 1'b0; ct_err <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (wait_cnt < mem_lat) begin
                    wait_cnt <= wait_cnt + 1;
                end else begin
                    wait_cnt <= 0;
                    mem_ack  <= 1'b1;
                    if (fail_en && mem_addr == fail_addr) begin
                        mem_err <= 1'b1;
                    end else if (mem_we) begin
                        wr_count <= wr_count + 1;
                        dtmem[6'((mem_addr - DT_BASE) >> 3)] <= mem_wdata;
                    end else begin
                        rd_count  <= rd_count + 1;
                        mem_rdata <= qmem[6'((mem_addr - Q_BASE) >> 3)];
                    end
                end
            end
            if (ct_req && !ct_ack) begin
                ct_ack <= 1'b1;
                if (ct_fail) begin
                    ct_err <= 1'b1;
                end else begin
                    ct_count  <= ct_count + 1;
                    last_id   <= ct_id;
                    last_proc <= ct_proc;
                    last_vld  <= ct_valid;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_cmd(input int idx, input logic [7:0] op, input logic [31:0] dev,
                           input logic [63:0] w2);
        qmem[idx*4]   = {dev, 24'h0, op};
        qmem[idx*4+1] = 64'hDEAD_0001_0000_0000 | 64'(idx);
        qmem[idx*4+2] = w2;
        qmem[idx*4+3] = 64'hDEAD_0003_0000_0000 | 64'(idx);
    endtask

    function automatic logic [63:0] mapc_w(input logic [15:0] cid, input logic [15:0] pn,
                                           input logic v);
        return {v, 31'h0, pn, cid};
    endfunction

    task automatic set_wptr(input logic [IDX_W-1:0] v);
        @(negedge clk);
        wptr_wr = 1'b1; wptr_wdata = v;
        @(negedge clk);
        wptr_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        stall_clr = 1'b1;
        @(negedge clk);
        stall_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk(rptr_o == 0, "R1 rptr", rptr_o, 0);
        chk(stalled_o == 0, "R1 stalled", stalled_o, 0);
        chk(!mem_req && !ct_req, "R1 req", {mem_req, ct_req}, 0);
    endtask

    task automatic t_sync();
        int r0, w0, c0;
        put_cmd(0, 8'h05, 32'h0, 64'h0);
        r0 = rd_count; w0 = wr_count; c0 = ct_count;
        set_wptr(1); run(12);
        chk(rptr_o == 1, "R2 sync consumed", rptr_o, 1);
        chk(rd_count - r0 == 1, "R7 sync reads", rd_count - r0, 1);
        chk(wr_count == w0 && ct_count == c0, "R7 sync side effects", wr_count - w0 + ct_count - c0, 0);
    endtask

    task automatic t_mapc();
        int c0;
        put_cmd(1, 8'h09, 32'h0, mapc_w(16'd5, 16'd2, 1'b1));
        put_cmd(2, 8'h09, 32'h0, mapc_w(16'd31, 16'd3, 1'b0));
        c0 = ct_count;
        set_wptr(2); run(15);
        chk(ct_count - c0 == 1, "R4 mapc one request", ct_count - c0, 1);
        chk(last_id == 5 && last_proc == 2 && last_vld == 1, "R4 mapc fields R3",
            {last_id, last_proc, 7'h0, last_vld}, {16'd5, 16'd2, 8'd1});
        set_wptr(3); run(15);
        chk(last_id == 31 && last_proc == 3 && last_vld == 0, "R4 mapc upper limits",
            {last_id, last_proc, 7'h0, last_vld}, {16'd31, 16'd3, 8'd0});
        chk(rptr_o == 3, "R4 rptr", rptr_o, 3);
    endtask

    task automatic t_mapc_range();
        int c0;
        put_cmd(3, 8'h09, 32'h0, mapc_w(16'd32, 16'd0, 1'b1));
        put_cmd(4, 8'h09, 32'h0, mapc_w(16'd0, 16'd4, 1'b1));
        c0 = ct_count;
        set_wptr(5); run(30);
        chk(ct_count == c0, "R5 out of range ignored", ct_count - c0, 0);
        chk(rptr_o == 5, "R5 rptr advanced", rptr_o, 5);
    endtask

    task automatic t_mapd();
        int w0;
        dtmem[63] = 64'hFFFF_FFFF_FFFF_FFFF;
        dtmem[0]  = 64'h1234;
        put_cmd(5, 8'h08, 32'd7,  64'h8000_0000_0ABC_D000);
        put_cmd(6, 8'h08, 32'd63, 64'h0000_0000_5555_0000);
        put_cmd(7, 8'h08, 32'd64, 64'h8000_0000_0000_0777);
        w0 = wr_count;
        set_wptr(8); run(40);
        chk(dtmem[7] == 64'h8000_0000_0ABC_D000, "R6 mapd entry", dtmem[7], 64'h8000_0000_0ABC_D000);
        chk(dtmem[63] == 0, "R6 mapd unmap writes zero", dtmem[63], 0);
        chk(wr_count - w0 == 2, "R6 device limit", wr_count - w0, 2);
        chk(dtmem[0] == 64'h1234, "R6 no aliased write", dtmem[0], 64'h1234);
        chk(rptr_o == 8, "R6 rptr", rptr_o, 8);
    endtask

    task automatic t_unknown();
        int r0, w0, c0;
        put_cmd(8, 8'h3F, 32'd1, mapc_w(16'd1, 16'd1, 1'b1));
        r0 = rd_count; w0 = wr_count; c0 = ct_count;
        set_wptr(9); run(12);
        chk(rptr_o == 9, "R8 unknown skipped", rptr_o, 9);
        chk(rd_count - r0 == 1 && wr_count == w0 && ct_count == c0, "R8 no side effects",
            rd_count - r0, 1);
    endtask

    task automatic t_wptr_ignore();
        int r0;
        r0 = rd_count;
        set_wptr(4'd12); run(12);
        chk(rptr_o == 9 && rd_count == r0, "R2 out-of-range wptr ignored", rptr_o, 9);
        set_wptr(4'd15); run(12);
        chk(rptr_o == 9 && rd_count == r0, "R2 wptr 15 ignored", rptr_o, 9);
    endtask

    task automatic t_wrap();
        int c0;
        put_cmd(9,  8'h05, 32'h0, 64'h0);
        put_cmd(10, 8'h05, 32'h0, 64'h0);
        put_cmd(11, 8'h05, 32'h0, 64'h0);
        put_cmd(0,  8'h09, 32'h0, mapc_w(16'd1, 16'd1, 1'b1));
        c0 = ct_count;
        set_wptr(0); run(30);
        chk(rptr_o == 0, "R9 wrapped to zero", rptr_o, 0);
        set_wptr(1); run(15);
        chk(rptr_o == 1 && ct_count - c0 == 1 && last_id == 1, "R9 entry 0 after wrap",
            rptr_o, 1);
    endtask

    task automatic t_fault_read();
        int c0, reqs;
        put_cmd(1, 8'h09, 32'h0, mapc_w(16'd3, 16'd0, 1'b1));
        fail_addr = Q_BASE + 32*1 + 16; fail_en = 1'b1;
        c0 = ct_count;
        set_wptr(2); run(15);
        chk(stalled_o == 1, "R10 read error stalls", stalled_o, 1);
        chk(rptr_o == 1 && ct_count == c0, "R10 rptr held", rptr_o, 1);
        reqs = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (mem_req || ct_req) reqs++;
        end
        chk(reqs == 0, "R10 no fetch while stalled", reqs, 0);
        fail_en = 1'b0;
        pulse_clr(); run(15);
        chk(stalled_o == 0 && rptr_o == 2, "R10 retry after clear", rptr_o, 2);
        chk(ct_count - c0 == 1 && last_id == 3, "R10 retried entry executed", last_id, 3);
    endtask

    task automatic t_fault_ct();
        put_cmd(2, 8'h09, 32'h0, mapc_w(16'd4, 16'd1, 1'b1));
        ct_fail = 1'b1;
        set_wptr(3); run(15);
        chk(stalled_o == 1 && rptr_o == 2, "R10 table refusal stalls", rptr_o, 2);
        ct_fail = 1'b0;
        pulse_clr(); run(15);
        chk(rptr_o == 3 && last_id == 4, "R10 table retry", rptr_o, 3);
    endtask

    task automatic t_fault_write();
        put_cmd(3, 8'h08, 32'd9, 64'h8000_0000_0000_0900);
        dtmem[9] = 64'h0;
        fail_addr = DT_BASE + 72; fail_en = 1'b1;
        set_wptr(4); run(15);
        chk(stalled_o == 1 && rptr_o == 3, "R10 write error stalls", rptr_o, 3);
        fail_en = 1'b0;
        pulse_clr(); run(15);
        chk(rptr_o == 4 && dtmem[9] == 64'h8000_0000_0000_0900, "R10 write retry", dtmem[9],
            64'h8000_0000_0000_0900);
    endtask

    task automatic t_slow();
        int c0;
        mem_lat = 3;
        put_cmd(4, 8'h09, 32'h0, mapc_w(16'd6, 16'd3, 1'b1));
        put_cmd(5, 8'h08, 32'd11, 64'h8000_0000_0000_0B00);
        c0 = ct_count;
        set_wptr(6); run(60);
        chk(rptr_o == 6 && ct_count - c0 == 1 && last_id == 6, "R11 slow responder mapc", rptr_o, 6);
        chk(dtmem[11] == 64'h8000_0000_0000_0B00, "R11 slow responder mapd", dtmem[11],
            64'h8000_0000_0000_0B00);
        mem_lat = 0;
    endtask

    initial begin
        for (int i = 0; i < 48; i++) qmem[i] = '0;
        for (int i = 0; i < 64; i++) dtmem[i] = '0;
        run(3);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        run(2);
        t_reset();
        t_sync();
        t_mapc();
        t_mapc_range();
        t_mapd();
        t_unknown();
        t_wptr_ignore();
        t_wrap();
        t_fault_read();
        t_fault_ct();
        t_fault_write();
        t_slow();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule